// File: doc/BRIEF.md
# Amplifier Fault Supervisor

This block makes the protection decisions for a two-channel switching power amplifier. It takes digital indications only: an active-low shutdown request, a power-on reset that stands for a supply cycle, a short-circuit detect pulse, a pair of die temperature comparators (one for over-temperature, one for recovered), and a duty measurement with a polarity bit for each channel. From these it drives two outputs. The first is an output enable; when it is low, the power stage is held in high impedance. The second is an active-low fault flag meant for an open-drain pin.

There are three fault classes, and each has its own rule for clearing. A DC fault is raised when a channel holds a large one-sided duty for too long. Only a supply cycle clears it. A short-circuit fault stays latched until shutdown is taken low. A thermal fault clears by itself once the cooled comparator fires, and it never shows on the flag. Feeding the flag back into the shutdown input gives automatic retry after a short. A millisecond tick input drives the power-up delay and the DC persistence timer.

Top module: `amp_fault_supervisor`

## Requirements
- R1: While the power-on reset `rst_n` is low and after it is released, all faults are clear, `out_en` is 0 and `flag_n` is 1.
- R2: `out_en` is 0 at once while `sd_n` is low. After `sd_n` goes high with no fault present, `out_en` becomes 1 at the clock edge of the 16th `ms_tick` counted with `sd_n` high.
- R3: A channel counts as over its limit when its 7-bit duty value (percent of differential duty) is strictly greater than 16. A DC fault is raised at the edge of the 501st consecutive `ms_tick` during which that channel stays over the limit with unchanged polarity. Either channel can raise it: channel 0 is `duty_bus[6:0]` with `pol_bus[0]`, and channel 1 is `duty_bus[13:7]` with `pol_bus[1]`.
- R4: A channel's persistence count returns to zero in any cycle where its duty is 16 or less, or where its polarity differs from the value seen in the previous clock cycle. The previous polarity is 0 after reset.
- R5: A DC fault forces `flag_n` to 0 and `out_en` to 0. It stays until `rst_n` is asserted, and cycling `sd_n` does not clear it.
- R6: A `short_det` pulse while `sd_n` is high latches a short fault, which forces `flag_n` to 0 and `out_en` to 0. Any cycle with `sd_n` low clears the latch, and `flag_n` returns to 1 if there is no DC fault.
- R7: With `flag_n` wired to `sd_n`, a short fault clears itself one clock later, and the outputs come back after the 16-tick power-up delay.
- R8: `therm_hot` sets a thermal fault and `therm_cool` clears it; when both are high, hot wins. A thermal fault forces `out_en` to 0, never changes `flag_n`, and when it clears, `out_en` returns without a new power-up delay.
- R9: While `sd_n` is low, both DC persistence counts are held at zero, so no DC fault can be raised.
- R10: A DC fault outranks a short fault, which outranks a thermal fault. When a DC fault and a short fault are both present, cycling `sd_n` leaves `flag_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (supply cycle) |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sd_n | input | 1 | Active-low shutdown request |
| short_det | input | 1 | Short-circuit detect pulse |
| therm_hot | input | 1 | Die over-temperature comparator |
| therm_cool | input | 1 | Die recovered comparator |
| duty_bus | input | 14 | Per-channel differential duty, 7 bits each, channel 0 in the low bits |
| pol_bus | input | 2 | Per-channel duty polarity |
| out_en | output | 1 | Output stage enable; 0 forces high impedance |
| flag_n | output | 1 | Active-low fault flag |

## Verification
The case that is hardest to reach from the ports is a DC trip at the exact persistence boundary. It needs 500 uninterrupted over-limit ticks with steady polarity, and random stimulus almost never produces that. The stimulus therefore holds channel duty above the limit with the tick running every cycle. It then checks the flag one edge before and one edge after the 501st tick, and repeats this after a mid-run dip in duty, after a polarity flip, and after a release from shutdown. Random segments hold duty high for long stretches and apply periodic resets, so that DC trips also happen in the middle of short and thermal activity. Those segments are compared against a cycle model kept in the bench.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_THERM = 2'd1,
    FC_SHORT = 2'd2,
    FC_DC    = 2'd3
  } fault_cls_t;

  // strict comparison against the duty limit
  function automatic logic duty_over(input logic [31:0] duty, input logic [31:0] lim);
    return duty > lim;
  endfunction

  // ranking of active faults: dc over short over thermal
  function automatic fault_cls_t pick_class(input logic dc, input logic sc, input logic th);
    if (dc)      return FC_DC;
    else if (sc) return FC_SHORT;
    else if (th) return FC_THERM;
    else         return FC_NONE;
  endfunction

  // only latched classes are reported externally
  function automatic logic class_flagged(input fault_cls_t c);
    return (c == FC_DC) || (c == FC_SHORT);
  endfunction

endpackage

// File: rtl/amp_dc_persist.sv
module amp_dc_persist #(
  parameter int DUTY_W   = 7,
  parameter int DUTY_LIM = 16,
  parameter int DC_MS    = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              arm,
  input  logic [DUTY_W-1:0] duty,
  input  logic              pol,
  output logic              trip,
  output logic              cnt_zero
);
  import amp_sup_pkg::*;

  localparam int CW = $clog2(DC_MS + 1);

  logic [CW-1:0] cnt;
  logic          pol_prev;
  logic          over;
  logic          hold_ok;

  assign over    = duty_over(32'(duty), 32'(DUTY_LIM));
  assign hold_ok = over && (pol == pol_prev) && arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pol_prev <= 1'b0;
    end else begin
      pol_prev <= pol;
      if (!hold_ok)
        cnt <= '0;
      else if (ms_tick && (cnt != CW'(DC_MS)))
        cnt <= cnt + 1'b1;
    end
  end

  assign trip     = hold_ok && ms_tick && (cnt == CW'(DC_MS));
  assign cnt_zero = (cnt == '0);

endmodule

// File: rtl/amp_start_timer.sv
module amp_start_timer #(
  parameter int STARTUP_MS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic arm,
  output logic done
);
  localparam int SW = $clog2(STARTUP_MS + 1);

  logic [SW-1:0] cnt;

  assign done = (cnt == SW'(STARTUP_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!arm)
      cnt <= '0;
    else if (ms_tick && !done)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/amp_fault_latch.sv
module amp_fault_latch (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sd_n,
  input  logic                    dc_trip,
  input  logic                    short_det,
  input  logic                    therm_hot,
  input  logic                    therm_cool,
  output logic                    dc_q,
  output logic                    sc_q,
  output logic                    th_q,
  output amp_sup_pkg::fault_cls_t cls
);
  import amp_sup_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q <= 1'b0;
      sc_q <= 1'b0;
      th_q <= 1'b0;
    end else begin
      if (dc_trip)
        dc_q <= 1'b1;
      if (!sd_n)
        sc_q <= 1'b0;
      else if (short_det)
        sc_q <= 1'b1;
      if (therm_hot)
        th_q <= 1'b1;
      else if (therm_cool)
        th_q <= 1'b0;
    end
  end

  assign cls = pick_class(dc_q, sc_q, th_q);

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor #(
  parameter int NCH        = 2,
  parameter int DUTY_W     = 7,
  parameter int DUTY_LIM   = 16,
  parameter int DC_MS      = 500,
  parameter int STARTUP_MS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ms_tick,
  input  logic                  sd_n,
  input  logic                  short_det,
  input  logic                  therm_hot,
  input  logic                  therm_cool,
  input  logic [NCH*DUTY_W-1:0] duty_bus,
  input  logic [NCH-1:0]        pol_bus,
  output logic                  out_en,
  output logic                  flag_n
);
  import amp_sup_pkg::*;

  logic [NCH-1:0] trip_vec;
  logic [NCH-1:0] zero_vec;
  logic           dc_trip;
  logic           dc_cnt_zero;
  logic           start_done;
  logic           dc_q;
  logic           sc_q;
  logic           th_q;
  fault_cls_t     cls;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    amp_dc_persist #(
      .DUTY_W  (DUTY_W),
      .DUTY_LIM(DUTY_LIM),
      .DC_MS   (DC_MS)
    ) u_persist (
      .clk     (clk),
      .rst_n   (rst_n),
      .ms_tick (ms_tick),
      .arm     (sd_n),
      .duty    (duty_bus[ch*DUTY_W +: DUTY_W]),
      .pol     (pol_bus[ch]),
      .trip    (trip_vec[ch]),
      .cnt_zero(zero_vec[ch])
    );
  end

  assign dc_trip     = |trip_vec;
  assign dc_cnt_zero = &zero_vec;

  amp_start_timer #(
    .STARTUP_MS(STARTUP_MS)
  ) u_start (
    .clk    (clk),
    .rst_n  (rst_n),
    .ms_tick(ms_tick),
    .arm    (sd_n),
    .done   (start_done)
  );

  amp_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_n      (sd_n),
    .dc_trip   (dc_trip),
    .short_det (short_det),
    .therm_hot (therm_hot),
    .therm_cool(therm_cool),
    .dc_q      (dc_q),
    .sc_q      (sc_q),
    .th_q      (th_q),
    .cls       (cls)
  );

  assign flag_n = !class_flagged(cls);
  assign out_en = sd_n && start_done && (cls == FC_NONE);

endmodule

// File: rtl/amp_fault_supervisor_chk.sv
module amp_fault_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic sd_n,
  input logic out_en,
  input logic flag_n,
  input logic dc_q,
  input logic sc_q,
  input logic th_q,
  input logic dc_trip,
  input logic dc_cnt_zero,
  input logic start_done
);

  a_r5_dc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dc_q |=> dc_q);

  a_r5_dc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dc_q |-> (!flag_n && !out_en));

  a_r3_dc_from_trip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dc_q) |-> $past(dc_trip));

  a_r6_short_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n |=> !sc_q);

  a_r8_thermal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    th_q |-> !out_en);

  a_r8_thermal_unflagged: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_q && !sc_q) |-> flag_n);

  a_r9_dc_held: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n |=> dc_cnt_zero);

  a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (sd_n && start_done));

endmodule

bind amp_fault_supervisor amp_fault_supervisor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sd_n       (sd_n),
  .out_en     (out_en),
  .flag_n     (flag_n),
  .dc_q       (dc_q),
  .sc_q       (sc_q),
  .th_q       (th_q),
  .dc_trip    (dc_trip),
  .dc_cnt_zero(dc_cnt_zero),
  .start_done (start_done)
);

// File: tb/amp_fault_supervisor_test.sv
`timescale 1ns/1ps
module amp_fault_supervisor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       sd_drv = 1'b0;
  logic       fb_mode = 1'b0;
  logic       short_det = 1'b0;
  logic       therm_hot = 1'b0;
  logic       therm_cool = 1'b0;
  logic [6:0] duty0 = '0;
  logic [6:0] duty1 = '0;
  logic [1:0] pol = '0;
  logic       out_en;
  logic       flag_n;
  logic       sd_n;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  assign sd_n = fb_mode ? flag_n : sd_drv;

  always #2.5 clk = ~clk;

  amp_fault_supervisor uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .sd_n      (sd_n),
    .short_det (short_det),
    .therm_hot (therm_hot),
    .therm_cool(therm_cool),
    .duty_bus  ({duty1, duty0}),
    .pol_bus   (pol),
    .out_en    (out_en),
    .flag_n    (flag_n)
  );

  // bench-side reference state, written from the requirements
  bit m_dc, m_sc, m_th;
  int m_st;
  int m_cnt [2];
  bit m_pp  [2];

  function automatic bit exp_flag();
    return !(m_dc || m_sc);
  endfunction

  function automatic bit exp_sd();
    return fb_mode ? exp_flag() : sd_drv;
  endfunction

  function automatic bit exp_out();
    return exp_sd() && (m_st == 16) && !m_dc && !m_sc && !m_th;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dc = 0; m_sc = 0; m_th = 0; m_st = 0;
      m_cnt[0] = 0; m_cnt[1] = 0; m_pp[0] = 0; m_pp[1] = 0;
    end else begin
      bit sdv;
      bit trip;
      int dv [2];
      sdv = exp_sd();
      dv[0] = int'(duty0);
      dv[1] = int'(duty1);
      trip = 0;
      for (int k = 0; k < 2; k++) begin
        bit ok;
        ok = (dv[k] > 16) && (pol[k] == m_pp[k]) && sdv;
        if (ok && ms_tick && m_cnt[k] == 500) trip = 1;
        if (!ok) m_cnt[k] = 0;
        else if (ms_tick && m_cnt[k] < 500) m_cnt[k]++;
        m_pp[k] = pol[k];
      end
      if (trip) m_dc = 1;
      if (!sdv) m_sc = 0;
      else if (short_det) m_sc = 1;
      if (therm_hot) m_th = 1;
      else if (therm_cool) m_th = 0;
      if (!sdv) m_st = 0;
      else if (ms_tick && m_st < 16) m_st++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(3);
    chk("R1 out_en in reset", out_en, 1'b0);
    chk("R1 flag_n in reset", flag_n, 1'b1);
    rst_n = 1'b1;
    step(2);
    chk("R1 flag_n after reset", flag_n, 1'b1);

    // R2 power-up delay
    ms_tick = 1'b1;
    sd_drv = 1'b1;
    step(15);
    chk("R2 out_en before 16th tick", out_en, 1'b0);
    step(1);
    chk("R2 out_en at 16th tick", out_en, 1'b1);
    sd_drv = 1'b0;
    #1;
    chk("R2 out_en with sd_n low", out_en, 1'b0);
    @(negedge clk);
    sd_drv = 1'b1;
    step(16);

    // R3 limit is strict and the trip is on the 501st tick
    duty0 = 7'd16;
    step(600);
    chk("R3 duty 16 never trips", flag_n, 1'b1);
    duty0 = 7'd17;
    step(500);
    chk("R3 no trip at 500 ticks", flag_n, 1'b1);
    step(1);
    chk("R3 trip at 501st tick flag", flag_n, 1'b0);
    chk("R5 dc trip disables output", out_en, 1'b0);
    duty0 = 7'd0;

    // R5 shutdown cycling does not clear
    sd_drv = 1'b0;
    step(3);
    sd_drv = 1'b1;
    step(20);
    chk("R5 flag after sd cycle", flag_n, 1'b0);
    chk("R5 out_en after sd cycle", out_en, 1'b0);
    do_reset();
    step(1);
    chk("R5 reset clears dc fault", flag_n, 1'b1);

    // R4 dip in duty restarts the count (channel 1)
    duty1 = 7'd40;
    pol[1] = 1'b1;
    step(300);
    duty1 = 7'd10;
    step(1);
    duty1 = 7'd40;
    step(500);
    chk("R4 count restarted after dip", flag_n, 1'b1);
    step(1);
    chk("R4 trip 501 ticks after dip", flag_n, 1'b0);
    do_reset();
    step(1);
    pol[1] = 1'b1;
    step(300);
    pol[1] = 1'b0;
    step(1);
    step(500);
    chk("R4 count restarted after polarity flip", flag_n, 1'b1);
    step(1);
    chk("R4 trip 501 ticks after flip", flag_n, 1'b0);
    duty1 = 7'd0;
    do_reset();

    // R9 count held while shutdown is low
    sd_drv = 1'b0;
    duty0 = 7'd50;
    pol[0] = 1'b0;
    step(700);
    chk("R9 no trip while shutdown", flag_n, 1'b1);
    sd_drv = 1'b1;
    step(500);
    chk("R9 counting only after release", flag_n, 1'b1);
    step(1);
    chk("R9 trip 501 ticks after release", flag_n, 1'b0);
    duty0 = 7'd0;
    do_reset();

    // R6 short latch cleared by shutdown cycle
    step(20);
    chk("R6 running before short", out_en, 1'b1);
    short_det = 1'b1;
    step(1);
    short_det = 1'b0;
    chk("R6 short flag", flag_n, 1'b0);
    chk("R6 short disables", out_en, 1'b0);
    step(5);
    chk("R6 short stays latched", flag_n, 1'b0);
    sd_drv = 1'b0;
    step(1);
    chk("R6 sd low clears flag", flag_n, 1'b1);
    sd_drv = 1'b1;
    step(15);
    chk("R6 waits for power-up delay", out_en, 1'b0);
    step(1);
    chk("R6 resumes after delay", out_en, 1'b1);

    // R10 dc outranks short
    short_det = 1'b1;
    step(1);
    short_det = 1'b0;
    duty0 = 7'd17;
    step(501);
    duty0 = 7'd0;
    sd_drv = 1'b0;
    step(1);
    chk("R10 dc keeps flag after short cleared", flag_n, 1'b0);
    sd_drv = 1'b1;
    do_reset();

    // R7 flag fed back into shutdown
    fb_mode = 1'b1;
    step(20);
    chk("R7 running in feedback mode", out_en, 1'b1);
    short_det = 1'b1;
    step(1);
    short_det = 1'b0;
    chk("R7 short flagged", flag_n, 1'b0);
    step(1);
    chk("R7 auto clear flag", flag_n, 1'b1);
    chk("R7 still off after clear", out_en, 1'b0);
    step(15);
    chk("R7 off before delay ends", out_en, 1'b0);
    step(1);
    chk("R7 auto recovered", out_en, 1'b1);
    fb_mode = 1'b0;
    sd_drv = 1'b1;

    // R8 thermal
    therm_hot = 1'b1;
    step(1);
    therm_hot = 1'b0;
    chk("R8 thermal disables", out_en, 1'b0);
    chk("R8 thermal not flagged", flag_n, 1'b1);
    step(10);
    chk("R8 thermal holds", out_en, 1'b0);
    therm_hot = 1'b1;
    therm_cool = 1'b1;
    step(1);
    therm_hot = 1'b0;
    therm_cool = 1'b0;
    chk("R8 hot wins over cool", out_en, 1'b0);
    therm_cool = 1'b1;
    step(1);
    therm_cool = 1'b0;
    chk("R8 resumes at once on cool", out_en, 1'b1);

    // random phase against the reference state
    begin
      bit hold_high;
      for (int seg = 0; seg < 24; seg++) begin
        hold_high = ($urandom % 2) == 0;
        if (seg % 4 == 0) do_reset();
        for (int c = 0; c < 900; c++) begin
          ms_tick    = hold_high ? 1'b1 : (($urandom % 4) != 0);
          short_det  = ($urandom % 500) == 0;
          therm_hot  = ($urandom % 300) == 0;
          therm_cool = ($urandom % 20) == 0;
          if (($urandom % 400) == 0) sd_drv = ~sd_drv;
          if (!hold_high && ($urandom % 700) == 0) sd_drv = 1'b1;
          if (hold_high) begin
            duty0 = 7'd17 + 7'($urandom % 60);
            duty1 = 7'($urandom % 17);
          end else begin
            duty0 = 7'($urandom % 40);
            duty1 = 7'($urandom % 40);
            if (($urandom % 1500) == 0) pol = pol ^ 2'b01;
            if (($urandom % 1500) == 0) pol = pol ^ 2'b10;
          end
          step(1);
          chk("R2/R5/R6 model out_en", out_en, exp_out());
          chk("R3/R8 model flag_n", flag_n, exp_flag());
        end
      end
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule